// File: doc/BRIEF.md
# Three-PLL Mode and Lock-Timer Controller

This block holds the control state for a group of PLLs and sequences their lock timing. For each PLL it keeps a power-on bit, a multiply/divide mode bit and an output-select bit (slow 32.768 kHz pass-through or PLL frequency). A global bit picks the oscillator that feeds the plain oscillator clock source. The bits are driven straight out to the clock tree. The PLL analog cores and the frequency arithmetic sit outside this block.

Each PLL has a 22-bit lock-time register, counted in peripheral-clock ticks, and a per-PLL sequencer with three states. LK_OFF is the state while the PLL is powered down. LK_COUNTING is the state while the timer runs. LK_DONE is the state after the timer has expired. The transitions are: start (power-on bit set: LK_OFF to LK_COUNTING, timer loaded), restart (count or PMS register written: LK_COUNTING or LK_DONE to LK_COUNTING, timer reloaded), expire (a tick while the timer is at zero: LK_COUNTING to LK_DONE) and stop (power-on bit cleared: any state to LK_OFF).

The status register reports two things per PLL. One is the timer-expired flag, which is not a real lock indication. The other is a divide-mode lock flag, taken from an external lock detector, that only means something in divide mode. A single-cycle register port gives write and read access. Reads are combinational.

Top module: `pll_lock_ctrl`

## Requirements
- R1: The mode register is at address 0. Its bit n (n = 0..2) powers PLL n on (1) or off (0). The value shows on `pll_en_o[n]` and in the read-back after the write cycle.
- R2: Mode register bit 4+n selects multiply mode (0) or divide mode (1) for PLL0 and PLL1, and shows on `pll_div_o`. PLL2 is divide-only: bit 6 always reads 1 and `pll_div_o[2]` is always 1, whatever is written.
- R3: Mode register bit 16+n selects the PLL n output (0 = 32.768 kHz pass-through, 1 = PLL frequency) on `pll_outsel_o`. Bit 8 selects the oscillator source (0 = main oscillator, 1 = 32.768 kHz) on `osc_sel_o`. All other mode bits read 0.
- R4: The lock-time register of PLL n is at address 2+n. It keeps bits 21:0 of the written value, and bits 31:22 read 0.
- R5: When PLL n is switched on, its timer loads the lock time and status bit n reads 0. With lock time N, status bit n becomes 1 after the (N+1)-th tick, so N = 0 sets it on the first tick.
- R6: The timer moves only on cycles where `tick_i` is 1. Without ticks, status bit n stays 0.
- R7: A write to the lock-time register or the PMS register of a PLL that is on clears status bit n and restarts the count from the lock-time value then in force.
- R8: Switching PLL n off clears status bits n and 4+n.
- R9: Status bit 4+n (status register at address 1) equals `dm_lock_i[n]` while PLL n is on and in divide mode. It is 0 otherwise.
- R10: The status register is read-only: writes to address 1 change no state. Unmapped addresses (8 and above) read 0.
- R11: The PMS register of PLL n is at address 5+n. It keeps the pre-divider bits 29:24, the main-divider bits 15:8 and the post-divider bits 2:0 (mask 0x3F00FF07). All other bits read 0.
- R12: After reset every PLL is off, every register reads 0 except mode bit 6, and every output is 0 except `pll_div_o[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Peripheral-clock tick strobe, one cycle per tick |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| dm_lock_i | input | 3 | External lock-detect flag per PLL |
| pll_en_o | output | 3 | PLL power-on per PLL |
| pll_div_o | output | 3 | 1 = divide mode, 0 = multiply mode |
| pll_outsel_o | output | 3 | 1 = PLL frequency, 0 = 32.768 kHz pass-through |
| osc_sel_o | output | 1 | Oscillator source select |

## Verification
On every cycle, the assertions check that a start or restart puts the sequencer in LK_COUNTING with the requested lock time, that the timer holds on cycles without a tick, and that a stop always reaches LK_OFF. They also check that a PLL that is off, or in multiply mode, never reports a lock flag. Only the bench scenarios can show the exact number of ticks to expiry, including the zero lock time. The same applies to the mask of each register, the fixed divide mode of PLL2, the read-only status address, and whether a restart clears the expired flag while the divide-mode flag is left alone.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    typedef enum logic [1:0] {
        LK_OFF      = 2'd0,
        LK_COUNTING = 2'd1,
        LK_DONE     = 2'd2
    } lk_state_e;

    // Bit positions in the mode and status words (decoded by the clock tree)
    localparam int MODE_DM_LSB  = 4;
    localparam int MODE_OSC_BIT = 8;
    localparam int MODE_OUT_LSB = 16;
    localparam int STAT_DM_LSB  = 4;

    // Word addresses
    localparam int ADDR_MODE = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CNT0 = 2;

    localparam logic [31:0] PMS_KEEP = 32'h3F00_FF07;

endpackage

// File: rtl/pllc_regs.sv
module pllc_regs
    import pllc_pkg::*;
#(
    parameter int NUM_PLL = 3,
    parameter int CNT_W   = 22,
    parameter int ADDR_W  = 4,
    parameter logic [NUM_PLL-1:0] DM_ONLY = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [31:0]              wdata_i,
    input  logic [31:0]              status_i,
    output logic [31:0]              rdata_o,
    output logic [NUM_PLL-1:0]       en_o,
    output logic [NUM_PLL-1:0]       dm_o,
    output logic [NUM_PLL-1:0]       osel_o,
    output logic                     osc_o,
    output logic [NUM_PLL-1:0]       start_o,
    output logic [NUM_PLL-1:0]       stop_o,
    output logic [NUM_PLL-1:0]       restart_o,
    output logic [NUM_PLL*CNT_W-1:0] load_o
);

    localparam int PMS_BASE = ADDR_CNT0 + NUM_PLL;

    logic [NUM_PLL-1:0] en_q, dm_q, osel_q;
    logic               osc_q;
    logic [CNT_W-1:0]   cnt_q [NUM_PLL];
    logic [31:0]        pms_q [NUM_PLL];
    logic               mode_wr;

    assign mode_wr = we_i && (addr_i == ADDR_W'(ADDR_MODE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            dm_q   <= DM_ONLY;
            osel_q <= '0;
            osc_q  <= 1'b0;
        end else if (mode_wr) begin
            en_q   <= wdata_i[NUM_PLL-1:0];
            dm_q   <= wdata_i[MODE_DM_LSB +: NUM_PLL] | DM_ONLY;
            osel_q <= wdata_i[MODE_OUT_LSB +: NUM_PLL];
            osc_q  <= wdata_i[MODE_OSC_BIT];
        end
    end

    generate
        for (genvar n = 0; n < NUM_PLL; n++) begin : g_pll
            logic cnt_wr, pms_wr;
            assign cnt_wr = we_i && (addr_i == ADDR_W'(ADDR_CNT0 + n));
            assign pms_wr = we_i && (addr_i == ADDR_W'(PMS_BASE + n));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q[n] <= '0;
                    pms_q[n] <= '0;
                end else begin
                    if (cnt_wr) cnt_q[n] <= wdata_i[CNT_W-1:0];
                    if (pms_wr) pms_q[n] <= wdata_i & PMS_KEEP;
                end
            end

            assign start_o[n]   = mode_wr && wdata_i[n] && !en_q[n];
            assign stop_o[n]    = mode_wr && !wdata_i[n] && en_q[n];
            assign restart_o[n] = cnt_wr || pms_wr;
            assign load_o[n*CNT_W +: CNT_W] = cnt_wr ? wdata_i[CNT_W-1:0] : cnt_q[n];
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADDR_MODE)) begin
            for (int n = 0; n < NUM_PLL; n++) begin
                rdata_o[n]                = en_q[n];
                rdata_o[MODE_DM_LSB + n]  = dm_q[n];
                rdata_o[MODE_OUT_LSB + n] = osel_q[n];
            end
            rdata_o[MODE_OSC_BIT] = osc_q;
        end else if (addr_i == ADDR_W'(ADDR_STAT)) begin
            rdata_o = status_i;
        end else begin
            for (int n = 0; n < NUM_PLL; n++) begin
                if (addr_i == ADDR_W'(ADDR_CNT0 + n)) rdata_o = 32'(cnt_q[n]);
                if (addr_i == ADDR_W'(PMS_BASE + n))  rdata_o = pms_q[n];
            end
        end
    end

    assign en_o   = en_q;
    assign dm_o   = dm_q;
    assign osel_o = osel_q;
    assign osc_o  = osc_q;

    // R10: a write to the status address leaves the mode state untouched
    assert_stat_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(ADDR_STAT)) |=> ($stable(en_q) && $stable(dm_q) && $stable(osel_q)));

endmodule

// File: rtl/pllc_lock_fsm.sv
module pllc_lock_fsm
    import pllc_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             tick_i,
    output logic             locked_o,
    output logic             active_o
);

    lk_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = tick_i && (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OFF: begin
                if (start_i) state_d = LK_COUNTING;                  // start
            end
            LK_COUNTING: begin
                if (stop_i)         state_d = LK_OFF;                // stop
                else if (restart_i) state_d = LK_COUNTING;           // restart
                else if (expire)    state_d = LK_DONE;               // expire
            end
            LK_DONE: begin
                if (stop_i)         state_d = LK_OFF;                // stop
                else if (restart_i) state_d = LK_COUNTING;           // restart
            end
            default: state_d = LK_OFF;
        endcase
    end

    // Lock timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if ((start_i && state_q == LK_OFF) || (restart_i && state_q != LK_OFF)) begin
            cnt_q <= load_i;
        end else if (state_q == LK_COUNTING && tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        locked_o = (state_q == LK_DONE);
        active_o = (state_q != LK_OFF);
    end

    assert_start_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == LK_OFF) |=> (state_q == LK_COUNTING && cnt_q == $past(load_i)));

    assert_restart_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !stop_i && state_q != LK_OFF) |=> (state_q == LK_COUNTING && cnt_q == $past(load_i)));

    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_COUNTING && !tick_i && !restart_i && !stop_i) |=> (state_q == LK_COUNTING && $stable(cnt_q)));

    assert_stop_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == LK_OFF));

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
    import pllc_pkg::*;
#(
    parameter int NUM_PLL = 3,
    parameter int CNT_W   = 22,
    parameter int ADDR_W  = 4,
    parameter logic [NUM_PLL-1:0] DM_ONLY = 3'b100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    input  logic [NUM_PLL-1:0] dm_lock_i,
    output logic [NUM_PLL-1:0] pll_en_o,
    output logic [NUM_PLL-1:0] pll_div_o,
    output logic [NUM_PLL-1:0] pll_outsel_o,
    output logic               osc_sel_o
);

    logic [NUM_PLL-1:0]       start_w, stop_w, restart_w, locked_w, active_w;
    logic [NUM_PLL*CNT_W-1:0] load_w;
    logic [31:0]              status_w;

    pllc_regs #(
        .NUM_PLL(NUM_PLL), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DM_ONLY(DM_ONLY)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .status_i(status_w), .rdata_o(reg_rdata_o),
        .en_o(pll_en_o), .dm_o(pll_div_o), .osel_o(pll_outsel_o), .osc_o(osc_sel_o),
        .start_o(start_w), .stop_o(stop_w), .restart_o(restart_w), .load_o(load_w)
    );

    generate
        for (genvar n = 0; n < NUM_PLL; n++) begin : g_lock
            pllc_lock_fsm #(.CNT_W(CNT_W)) fsm_i (
                .clk(clk), .rst_n(rst_n),
                .start_i(start_w[n]), .stop_i(stop_w[n]), .restart_i(restart_w[n]),
                .load_i(load_w[n*CNT_W +: CNT_W]), .tick_i(tick_i),
                .locked_o(locked_w[n]), .active_o(active_w[n])
            );

            // R8: a PLL that is off reports neither flag
            assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !pll_en_o[n] |-> (!status_w[n] && !status_w[STAT_DM_LSB + n]));

            // R9: multiply mode never reports a divide-mode lock
            assert_mm_no_dmlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !pll_div_o[n] |-> !status_w[STAT_DM_LSB + n]);
        end
    endgenerate

    always_comb begin
        status_w = '0;
        for (int n = 0; n < NUM_PLL; n++) begin
            status_w[n]               = locked_w[n];
            status_w[STAT_DM_LSB + n] = active_w[n] & pll_div_o[n] & dm_lock_i[n];
        end
    end

endmodule

// File: tb/pll_lock_ctrl_tb.sv
`timescale 1ns/1ps
module pll_lock_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  dm_lock = '0;
    logic [2:0]  en, dv, osel;
    logic        osc;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pll_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .dm_lock_i(dm_lock), .pll_en_o(en), .pll_div_o(dv),
        .pll_outsel_o(osel), .osc_sel_o(osc)
    );

    // {write data, expected mode read-back}
    localparam logic [63:0] MODE_TBL [6] = '{
        64'hFFFF_FFFF_0007_0177,
        64'h0000_0000_0000_0040,
        64'h0000_0030_0000_0070,
        64'h0001_0100_0001_0140,
        64'h0006_0005_0006_0045,
        64'h0000_01C8_0000_0140
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd(4'd0, v); check("R12 mode", v, 32'h40);
        rd(4'd1, v); check("R12 status", v, 32'h0);
        rd(4'd2, v); check("R12 count0", v, 32'h0);
        check("R12 ports", {24'd0, en, dv, osel, osc}, {24'd0, 3'b000, 3'b100, 3'b000, 1'b0});

        // R1 R2 R3: mode register table
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w, e;
            w = MODE_TBL[i][63:32];
            e = MODE_TBL[i][31:0];
            wr(4'd0, w);
            rd(4'd0, v); check("R1/R2/R3 readback", v, e);
            check("R1 pll_en", 32'(en), 32'(w[2:0]));
            check("R2 pll_div", 32'(dv), 32'({1'b1, w[5:4]}));
            check("R3 outsel/osc", 32'({osel, osc}), 32'({w[18:16], w[8]}));
        end
        wr(4'd0, 32'h0);

        // R4, R11: register masks
        wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); check("R4 count width", v, 32'h003F_FFFF);
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, v); check("R11 pms mask", v, 32'h3F00_FF07);

        // R5 R6: lock time 3 in multiply mode
        dm_lock = 3'b111;
        wr(4'd2, 32'd3);
        wr(4'd0, 32'h1);
        rd(4'd1, v); check("R5 status after enable", v, 32'h0);
        repeat (5) @(negedge clk);
        rd(4'd1, v); check("R6 no tick no lock", v, 32'h0);
        ticks(3);
        rd(4'd1, v); check("R5 before expiry", v, 32'h0);
        ticks(1);
        rd(4'd1, v); check("R5/R9 expiry, no dm flag in multiply", v, 32'h1);

        // R9: divide mode reports lock detect
        wr(4'd0, 32'h11);
        rd(4'd1, v); check("R9 divide-mode flag", v, 32'h11);
        dm_lock = 3'b110;
        rd(4'd1, v); check("R9 follows detector", v, 32'h01);
        dm_lock = 3'b111;

        // R7: PMS write restarts, then zero lock time
        wr(4'd5, 32'h0100_2001);
        rd(4'd1, v); check("R7 pms restart clears", v, 32'h10);
        wr(4'd2, 32'd0);
        rd(4'd1, v); check("R7 count restart", v, 32'h10);
        ticks(1);
        rd(4'd1, v); check("R5 zero lock time first tick", v, 32'h11);

        // R10: status read-only, unmapped reads 0
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, v); check("R10 status unchanged", v, 32'h11);
        rd(4'd0, v); check("R10 mode unchanged", v, 32'h51);
        rd(4'd15, v); check("R10 unmapped", v, 32'h0);

        // R8: switching off clears both flags
        wr(4'd0, 32'h0);
        rd(4'd1, v); check("R8 off clears", v, 32'h0);

        // R2 R5: PLL2 always divide mode
        wr(4'd4, 32'd1);
        wr(4'd0, 32'h4);
        rd(4'd1, v); check("R2 pll2 dm flag", v, 32'h40);
        ticks(2);
        rd(4'd1, v); check("R5 pll2 expiry", v, 32'h44);
        rd(4'd0, v); check("R2 pll2 mode bit", v, 32'h44);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule